// File: doc/BRIEF.md
# Receive Interrupt Coalescing Timer

This block decides when each of several DMA receive rings raises its completion interrupt. Every ring counts the packets that complete after its last acknowledge and compares the count with a packet threshold. It also runs an idle timeout, measured in coarse ticks. A shared prescaler makes one tick every `PRESCALE` core clocks; 1024 clocks of a 125 MHz base clock give about 8.192 us per tick. The timeout starts with the first packet after an acknowledge. Whichever limit is reached first raises the ring's interrupt, and the interrupt then stays high until software acknowledges that ring.

Software programs each ring's threshold and its 16-bit timeout through a single write port that selects one ring at a time. The default configuration has four priority rings plus one default ring. A write that would leave a ring unable to interrupt is refused: the ring keeps its old settings and a sticky error flag is set.

A build parameter turns the block into its transmit-side form. In that form the timeout is not used. A ring interrupts when its threshold count is reached, or when the ring reports empty while completed packets are still unacknowledged.

Top module: `coal_irq_ctrl`

## Requirements
- R1: After reset every interrupt output is 0 and the configuration error flag is 0. Every ring starts with threshold 1 and timeout 0, so a single completed packet raises its interrupt.
- R2: When a ring's threshold is non-zero, its interrupt goes high on the clock edge that samples the threshold-th `pkt_done` pulse since the last acknowledge. The threshold can be reached before the timeout. Once high, the interrupt stays high until it is acknowledged.
- R3: In receive mode with a non-zero timeout T, the timer starts on the first packet after an acknowledge. The timer counts only prescaler ticks. The interrupt rises between (T-1)*PRESCALE+1 and T*PRESCALE clock edges after the edge that sampled that packet, unless the threshold fires earlier.
- R4: While a ring has no packets pending, its timer holds and never raises the interrupt, both after reset and after an acknowledge.
- R5: An `irq_ack` bit clears that ring's interrupt, its packet count and its timer on the next edge. A packet completing in the same cycle as the acknowledge counts as the first packet of the next interval.
- R6: In receive mode a threshold of 0 disables the count trigger, so only the timeout can raise the interrupt.
- R7: A write with both threshold and timeout equal to 0 is illegal. It is rejected, it sets `cfg_err`, and the ring keeps its previous settings. `cfg_err` stays 1 until reset, even across later legal writes.
- R8: The rings are independent. Packets, settings and acknowledges of one ring never change another ring's interrupt.
- R9: In transmit mode the timeout field has no effect. An interrupt is raised when the threshold is reached. It is also raised on an edge where `ring_empty` is 1 and at least one packet is pending, counting a packet completing in that same cycle. `ring_empty` with nothing pending has no effect.
- R10: In transmit mode a threshold of 0 is illegal. It is rejected and sets `cfg_err`, whatever the timeout is.
- R11: A write whose ring index is not below the number of rings (5 to 7 by default) is rejected and sets `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ring | input | RING_W | Ring selected by the write |
| cfg_thresh | input | CNT_W | Packet threshold to write |
| cfg_timeout | input | TMO_W | Timeout in prescaler ticks to write |
| cfg_err | output | 1 | Sticky flag, set by a rejected write |
| pkt_done | input | NUM_RINGS | One pulse per completed packet, one bit per ring |
| ring_empty | input | NUM_RINGS | Ring-empty indication per ring (transmit mode only) |
| irq_ack | input | NUM_RINGS | Interrupt acknowledge per ring |
| irq | output | NUM_RINGS | Coalesced interrupt per ring |

## Verification
Each interrupt, acknowledge and configuration result appears on the first rising edge that samples the stimulus. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each threshold step is checked exactly one edge after its packet. The tick phase is free-running, so the exact expiry edge depends on where the prescaler happens to be. Timeout checks therefore sample twice: once at the last edge where the interrupt must still be low, (T-1)*PRESCALE edges after the first packet, and once at the first edge by which it must be high, T*PRESCALE edges after that packet.

// File: rtl/coal_pkg.sv
// Shared types for the interrupt coalescing block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package coal_pkg;
    // Build-time selection between receive and transmit behaviour
    typedef enum logic {
        COAL_RX = 1'b0,
        COAL_TX = 1'b1
    } coal_mode_e;
endpackage

// File: rtl/coal_prescaler.sv
// Free-running divider that emits a one-cycle tick every DIV core clocks.
// Assumes DIV >= 2. The tick is registered and is shared by all rings.
module coal_prescaler #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             tick_q;

    // Count core clocks and flag the last one of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
            tick_q <= (div_q == LAST);
        end
    end

    assign tick = tick_q;

    if (DIV > 1) begin : g_chk
        // R3: ticks are isolated single-cycle pulses
        a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick_q |=> !tick_q);
    end
endmodule

// File: rtl/coal_cfg_regs.sv
// Per-ring threshold and timeout registers behind a single write port.
// Checks each write for legality, rejects an illegal write and keeps a
// sticky error flag. Assumes cfg_ring is only meaningful while we is high.
module coal_cfg_regs
    import coal_pkg::*;
#(
    parameter int         NUM_RINGS = 5,
    parameter int         CNT_W     = 8,
    parameter int         TMO_W     = 16,
    parameter coal_mode_e MODE      = COAL_RX,
    localparam int        RING_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [RING_W-1:0]                ring,
    input  logic [CNT_W-1:0]                 thresh,
    input  logic [TMO_W-1:0]                 timeout,
    output logic [NUM_RINGS-1:0][CNT_W-1:0]  thr_o,
    output logic [NUM_RINGS-1:0][TMO_W-1:0]  tmo_o,
    output logic                             err_o
);
    localparam logic [RING_W:0] RING_LIMIT = (RING_W+1)'(NUM_RINGS);

    logic [NUM_RINGS-1:0][CNT_W-1:0] thr_q;
    logic [NUM_RINGS-1:0][TMO_W-1:0] tmo_q;
    logic                            err_q;
    logic                            in_range;
    logic                            value_ok;
    logic                            legal;

    // Decide whether the presented write may be applied
    always_comb begin
        in_range = ({1'b0, ring} < RING_LIMIT);
        if (MODE == COAL_TX) value_ok = (thresh != '0);
        else                 value_ok = (thresh != '0) || (timeout != '0);
        legal = in_range && value_ok;
    end

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        // Hold this ring's settings, update on a legal write addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q[g] <= CNT_W'(1);
                tmo_q[g] <= '0;
            end else if (we && legal && (ring == RING_W'(g))) begin
                thr_q[g] <= thresh;
                tmo_q[g] <= timeout;
            end
        end
    end

    // Remember any rejected write until reset
    always_ff @(posedge clk) begin
        if (!rst_n)             err_q <= 1'b0;
        else if (we && !legal)  err_q <= 1'b1;
    end

    assign thr_o = thr_q;
    assign tmo_o = tmo_q;
    assign err_o = err_q;

    // R7: a rejected write leaves every setting as it was
    a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !legal) |=> ($stable(thr_q) && $stable(tmo_q)));
    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/coal_ring_ctr.sv
// Coalescing state of one ring: a pending-packet count, an idle timer in
// prescaler ticks (receive mode) or an empty-ring trigger (transmit mode),
// and a sticky interrupt cleared by acknowledge. Assumes tick is one cycle.
module coal_ring_ctr
    import coal_pkg::*;
#(
    parameter int         CNT_W = 8,
    parameter int         TMO_W = 16,
    parameter coal_mode_e MODE  = COAL_RX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pkt,
    input  logic             ack,
    input  logic             empty,
    input  logic [CNT_W-1:0] thresh,
    input  logic [TMO_W-1:0] tmo,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [TMO_W-1:0] TMR_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_nx;
    logic [TMO_W-1:0] tmr_q;
    logic             irq_q, irq_nx;
    logic             hit_cnt, expire, empty_hit;

    // Next packet count: acknowledge restarts the interval, same-cycle packet counts
    always_comb begin
        cnt_base = ack ? '0 : cnt_q;
        cnt_nx   = (pkt && (cnt_base != CNT_MAX)) ? cnt_base + 1'b1 : cnt_base;
        hit_cnt  = (thresh != '0) && (cnt_nx >= thresh);
        irq_nx   = (irq_q && !ack) || hit_cnt || expire || empty_hit;
    end

    if (MODE == COAL_RX) begin : g_rx
        logic tmr_run;

        // Timer advances on ticks while packets are pending and a timeout is set
        always_comb begin
            tmr_run   = tick && !ack && (cnt_q != '0) && (tmo != '0);
            expire    = tmr_run && (tmr_q >= tmo - 1'b1);
            empty_hit = 1'b0;
        end

        // Keep the idle timer, cleared by acknowledge
        always_ff @(posedge clk) begin
            if (!rst_n)                          tmr_q <= '0;
            else if (ack)                        tmr_q <= '0;
            else if (tmr_run && tmr_q != TMR_MAX) tmr_q <= tmr_q + 1'b1;
        end

        logic unused_rx;
        assign unused_rx = empty;

        // R4: the timer stays at zero while nothing is pending
        a_r4_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == '0) |-> (tmr_q == '0));
    end else begin : g_tx
        // No timer; an empty ring with pending packets interrupts
        always_comb begin
            expire    = 1'b0;
            empty_hit = empty && (cnt_nx != '0);
        end
        assign tmr_q = '0;

        logic unused_tx;
        assign unused_tx = tick ^ (^tmo) ^ (^tmr_q);

        // R9: without packets, empty or a new threshold the interrupt cannot rise
        a_r9_tx_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_q && !pkt && !empty && $stable(thresh)) |=> !irq_q);
    end

    // Register the pending count and the sticky interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            irq_q <= irq_nx;
        end
    end

    assign irq = irq_q;

    // R2: once raised, the interrupt holds until acknowledged
    a_r2_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack) |=> irq_q);
    // R2: the threshold-th packet raises the interrupt on its edge
    a_r2_count_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt && !ack && (thresh != '0) && (cnt_q == thresh - 1'b1)) |=> irq_q);
    // R5: an acknowledge without a new packet clears the interrupt
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pkt) |=> !irq_q);
endmodule

// File: rtl/coal_irq_ctrl.sv
// Top of the interrupt coalescing block: shared tick prescaler, per-ring
// configuration registers and one coalescing counter per ring.
// Assumes all inputs are synchronous to clk; MODE fixes receive or transmit form.
module coal_irq_ctrl
    import coal_pkg::*;
#(
    parameter int         NUM_RINGS = 5,
    parameter int         CNT_W     = 8,
    parameter int         TMO_W     = 16,
    parameter int         PRESCALE  = 1024,
    parameter coal_mode_e MODE      = COAL_RX,
    localparam int        RING_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RING_W-1:0]    cfg_ring,
    input  logic [CNT_W-1:0]     cfg_thresh,
    input  logic [TMO_W-1:0]     cfg_timeout,
    output logic                 cfg_err,
    input  logic [NUM_RINGS-1:0] pkt_done,
    input  logic [NUM_RINGS-1:0] ring_empty,
    input  logic [NUM_RINGS-1:0] irq_ack,
    output logic [NUM_RINGS-1:0] irq
);
    logic                            tick;
    logic [NUM_RINGS-1:0][CNT_W-1:0] thr;
    logic [NUM_RINGS-1:0][TMO_W-1:0] tmo;

    coal_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    coal_cfg_regs #(
        .NUM_RINGS (NUM_RINGS),
        .CNT_W     (CNT_W),
        .TMO_W     (TMO_W),
        .MODE      (MODE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .ring    (cfg_ring),
        .thresh  (cfg_thresh),
        .timeout (cfg_timeout),
        .thr_o   (thr),
        .tmo_o   (tmo),
        .err_o   (cfg_err)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        coal_ring_ctr #(
            .CNT_W (CNT_W),
            .TMO_W (TMO_W),
            .MODE  (MODE)
        ) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .pkt    (pkt_done[g]),
            .ack    (irq_ack[g]),
            .empty  (ring_empty[g]),
            .thresh (thr[g]),
            .tmo    (tmo[g]),
            .irq    (irq[g])
        );
    end
endmodule

// File: tb/coal_irq_ctrl_tb_top.sv
module coal_irq_ctrl_tb_top;
    localparam int N  = 5;
    localparam int CW = 4;
    localparam int TW = 16;
    localparam int P  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_ring = '0;
    logic [CW-1:0] cfg_thr = '0;
    logic [TW-1:0] cfg_tmo = '0;
    logic [N-1:0]  pkt = '0;
    logic [N-1:0]  empty = '0;
    logic [N-1:0]  ack = '0;
    logic [N-1:0]  irq_rx, irq_tx;
    logic          err_rx, err_tx;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    coal_irq_ctrl #(.NUM_RINGS(N), .CNT_W(CW), .TMO_W(TW), .PRESCALE(P),
                    .MODE(coal_pkg::COAL_RX)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
        .cfg_thresh(cfg_thr), .cfg_timeout(cfg_tmo), .cfg_err(err_rx),
        .pkt_done(pkt), .ring_empty(empty), .irq_ack(ack), .irq(irq_rx));

    coal_irq_ctrl #(.NUM_RINGS(N), .CNT_W(CW), .TMO_W(TW), .PRESCALE(P),
                    .MODE(coal_pkg::COAL_TX)) dut_tx_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
        .cfg_thresh(cfg_thr), .cfg_timeout(cfg_tmo), .cfg_err(err_tx),
        .pkt_done(pkt), .ring_empty(empty), .irq_ack(ack), .irq(irq_tx));

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_cfg(input int r, input int t, input int tmo);
        cfg_we = 1'b1; cfg_ring = 3'(r); cfg_thr = CW'(t); cfg_tmo = TW'(tmo);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_pkt(input int r);
        pkt[r] = 1'b1;
        step();
        pkt = '0;
    endtask

    task automatic ack_ring(input int r);
        ack[r] = 1'b1;
        step();
        ack = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            summary();
            $finish;
        end
    end

    initial begin
        step();
        do_reset();
        // R1: reset state and default threshold of one packet
        check("R1 irq_rx", int'(irq_rx), 0);
        check("R1 irq_tx", int'(irq_tx), 0);
        check("R1 err_rx", int'(err_rx), 0);
        check("R1 err_tx", int'(err_tx), 0);
        pulse_pkt(2);
        check("R1 default thresh", int'(irq_rx), 4);
        ack_ring(2);
        check("R5 ack clears", int'(irq_rx), 0);

        // R2 / R8: threshold sweep over every ring, count-only
        for (int r = 0; r < N; r++) begin
            for (int t = 1; t < 16; t++) begin
                write_cfg(r, t, 0);
                for (int k = 1; k <= t; k++) begin
                    pulse_pkt(r);
                    check("R2 count", int'(irq_rx[r]), (k >= t) ? 1 : 0);
                    if (k % 3 == 0) step();
                end
                check("R8 others quiet", int'(irq_rx & ~(N'(1) << r)), 0);
                repeat (3) step();
                check("R2 sticky", int'(irq_rx[r]), 1);
                ack_ring(r);
                check("R5 cleared", int'(irq_rx[r]), 0);
            end
        end

        // R5: packet in the acknowledge cycle starts the next interval
        write_cfg(1, 2, 0);
        pulse_pkt(1); pulse_pkt(1);
        check("R5 pre", int'(irq_rx[1]), 1);
        pkt[1] = 1'b1; ack[1] = 1'b1; step(); pkt = '0; ack = '0;
        check("R5 ack+pkt", int'(irq_rx[1]), 0);
        pulse_pkt(1);
        check("R5 carried pkt counted", int'(irq_rx[1]), 1);
        ack_ring(1);
        pulse_pkt(1);
        check("R5 plain ack restarts", int'(irq_rx[1]), 0);
        ack_ring(1);

        // R3: timeout window for several timeout values
        for (int tm = 1; tm <= 4; tm++) begin
            int r = tm;
            write_cfg(r, 15, tm);
            pulse_pkt(r);
            repeat ((tm - 1) * P) step();
            check("R3 not early", int'(irq_rx[r]), 0);
            repeat (P) step();
            check("R3 expired", int'(irq_rx[r]), 1);
            check("R8 timeout isolated", int'(irq_rx & ~(N'(1) << r)), 0);
            ack_ring(r);
            check("R5 timeout ack", int'(irq_rx[r]), 0);
        end

        // R6: threshold 0 leaves only the timeout
        write_cfg(0, 0, 2);
        check("R6 legal in rx", int'(err_rx), 0);
        pulse_pkt(0); pulse_pkt(0); pulse_pkt(0);
        check("R6 count ignored", int'(irq_rx[0]), 0);
        repeat (2 * P - 3) step();
        check("R6 timeout fires", int'(irq_rx[0]), 1);
        ack_ring(0);

        // R4: timer holds with nothing pending
        write_cfg(4, 3, 1);
        repeat (4 * P) step();
        check("R4 idle after reset", int'(irq_rx[4]), 0);
        pulse_pkt(4);
        repeat (P) step();
        check("R3 one tick", int'(irq_rx[4]), 1);
        ack_ring(4);
        repeat (4 * P) step();
        check("R4 idle after ack", int'(irq_rx[4]), 0);

        // R2: threshold wins over a longer timeout
        write_cfg(3, 2, 4);
        pulse_pkt(3);
        check("R2 one of two", int'(irq_rx[3]), 0);
        pulse_pkt(3);
        check("R2 before timeout", int'(irq_rx[3]), 1);
        ack_ring(3);

        // R7: illegal write rejected, old threshold kept, flag sticky
        write_cfg(1, 3, 0);
        check("R7 legal write", int'(err_rx), 0);
        write_cfg(1, 0, 0);
        check("R7 flag set", int'(err_rx), 1);
        pulse_pkt(1); pulse_pkt(1);
        check("R7 old thresh kept", int'(irq_rx[1]), 0);
        pulse_pkt(1);
        check("R7 old thresh fires", int'(irq_rx[1]), 1);
        ack_ring(1);
        write_cfg(2, 1, 0);
        check("R7 flag sticky", int'(err_rx), 1);

        // R11: ring index out of range
        do_reset();
        write_cfg(5, 1, 0);
        check("R11 ring 5", int'(err_rx), 1);
        do_reset();
        write_cfg(7, 2, 3);
        check("R11 ring 7", int'(err_rx), 1);
        pulse_pkt(0);
        check("R11 ring 0 untouched", int'(irq_rx[0]), 1);

        // R10: transmit threshold 0 is illegal
        do_reset();
        write_cfg(0, 4, 0);
        check("R10 legal tx", int'(err_tx), 0);
        write_cfg(0, 0, 5);
        check("R10 tx zero thresh", int'(err_tx), 1);
        check("R10 rx accepts same", int'(err_rx), 0);
        pulse_pkt(0); pulse_pkt(0); pulse_pkt(0);
        check("R10 old tx thresh", int'(irq_tx[0]), 0);
        pulse_pkt(0);
        check("R10 old tx fires", int'(irq_tx[0]), 1);
        ack_ring(0);

        // R9: transmit threshold sweep
        do_reset();
        for (int r = 0; r < N; r++) begin
            for (int t = 1; t <= 6; t++) begin
                write_cfg(r, t, 1);
                for (int k = 1; k <= t; k++) begin
                    pulse_pkt(r);
                    check("R9 tx count", int'(irq_tx[r]), (k >= t) ? 1 : 0);
                end
                ack_ring(r);
                check("R9 tx ack", int'(irq_tx[r]), 0);
            end
        end

        // R9: no timeout in transmit mode, empty ring triggers
        write_cfg(2, 5, 1);
        pulse_pkt(2); pulse_pkt(2);
        repeat (4 * P) step();
        check("R9 no tx timeout", int'(irq_tx[2]), 0);
        empty[2] = 1'b1; step(); empty = '0;
        check("R9 empty fires", int'(irq_tx[2]), 1);
        ack_ring(2);
        check("R9 ack", int'(irq_tx[2]), 0);
        empty[2] = 1'b1; step(); empty = '0;
        check("R9 empty without pending", int'(irq_tx[2]), 0);
        pkt[2] = 1'b1; empty[2] = 1'b1; step(); pkt = '0; empty = '0;
        check("R9 empty with same-cycle pkt", int'(irq_tx[2]), 1);
        check("R8 tx others quiet", int'(irq_tx & ~(N'(1) << 2)), 0);
        ack_ring(2);

        done = 1;
        summary();
        $finish;
    end
endmodule